// File: doc/BRIEF.md
# Viewport Scan Origin Unit

This block produces the per-line display-buffer word address and the sub-word pixel shift for a viewport that is panned and scrolled across a larger stored image. A host programs a 24-bit starting word offset as three byte registers, a 2-bit pixel shift, and a 16-bit line stride (the virtual image width in words). All of these land in shadow registers first. The starting offset and the stride are copied into the fetch logic only when the timing generator pulses its frame strobe. The pixel shift is copied on every line strobe. Partial host updates therefore never reach the screen in the middle of a frame.

For each line strobe the block presents the word address of that line's first fetch. The first line of a frame starts at the captured offset, and each later line adds the captured stride, modulo 2^24. A status register returns the vertical non-display flag supplied by the timing generator in bit 7. Software waits for that bit to rise, writes the offset bytes, and then writes the pixel shift, so every change lands cleanly at a frame boundary.

The per-line output is a pure producer with no back-pressure. `line_valid` pulses for one cycle, and `fetch_addr` and `pix_shift` are valid in that cycle and hold until the next pulse. A display line cannot be stalled, so the consumer must take each pulse when it comes; there is no ready input. The host port is a plain synchronous register port: writes take effect at the clock edge where `host_we` is high, and reads are combinational from `host_addr`. Pixel shift matters only at colour depths below 15 bpp. At 15/16 bpp and above, software keeps it at zero and moves horizontally with the word offset alone.

Top module: `vp_scan_origin`

## Requirements
- R1: After reset, every shadow register reads 0, `fetch_addr` and `pix_shift` are 0, and `line_valid` is 0.
- R2: Host writes to offsets 0, 1 and 2 set bits [7:0], [15:8] and [23:16] of the start-offset shadow. Writes to offsets 4 and 5 set bits [7:0] and [15:8] of the stride shadow. Reading any of these offsets returns the shadow byte.
- R3: A change to the start-offset shadow does not reach `fetch_addr` before the next frame strobe. A write made in the same cycle as a frame strobe is not captured by that strobe.
- R4: The first line strobe after a frame strobe yields `fetch_addr` equal to the start offset captured at that frame strobe.
- R5: Each further line strobe in the frame yields the previous line's address plus the stride captured at the frame strobe, wrapping modulo 2^24.
- R6: Offset 3 bits [1:0] hold the pixel-shift shadow. Each line strobe copies it to `pix_shift`, so a mid-frame write takes effect on the next line.
- R7: `line_valid` is high exactly in the cycle after a line strobe. `fetch_addr` and `pix_shift` change only in that cycle and otherwise hold.
- R8: Reading offset 6 returns the vertical non-display input in bit 7, with bits [6:0] zero.
- R9: When frame and line strobes coincide, that line uses the start offset being captured, and the next line adds the stride to it.
- R10: Writes to offset 7 change no register, and offset 3 bits [7:2] read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Write byte |
| host_we | input | 1 | Write strobe |
| host_rdata | output | 8 | Combinational read data |
| vnd_in | input | 1 | Vertical non-display flag from timing |
| frame_start | input | 1 | One-cycle pulse at start of frame |
| line_start | input | 1 | One-cycle pulse at start of each active line |
| fetch_addr | output | 24 | First word address of the current line |
| pix_shift | output | 2 | Sub-word pixel shift for the current line |
| line_valid | output | 1 | One-cycle pulse marking new line values |

## Verification
The hardest situations to reach are the ones where a host write or a frame strobe lands on exactly the same edge as another event. One case is a start-offset write in the frame-strobe cycle, which must be missed. The other is a frame strobe coinciding with a line strobe, where the line must use the newly captured offset. The bench drives these edges on purpose from its vector table and a directed test. It also drives an offset near 2^24 so that the stride addition wraps.

// File: rtl/vp_pkg.sv
package vp_pkg;
  localparam int HOST_DW = 8;
  // register layout derived from field byte counts
  function automatic int ofs_org(input int i);
    return i;
  endfunction
  function automatic int ofs_pan(input int org_bytes);
    return org_bytes;
  endfunction
  function automatic int ofs_stride(input int org_bytes, input int i);
    return org_bytes + 1 + i;
  endfunction
  function automatic int ofs_status(input int org_bytes, input int stride_bytes);
    return org_bytes + 1 + stride_bytes;
  endfunction
endpackage

// File: rtl/vp_host_regs.sv
module vp_host_regs
  import vp_pkg::*;
#(
  parameter int ORG_BYTES    = 3,
  parameter int STRIDE_BYTES = 2,
  parameter int PAN_W        = 2,
  parameter int RA_W         = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RA_W-1:0]            ra,
  input  logic [HOST_DW-1:0]         wd,
  input  logic                       we,
  input  logic                       vnd,
  output logic [HOST_DW-1:0]         rd,
  output logic [8*ORG_BYTES-1:0]     org_sh,
  output logic [8*STRIDE_BYTES-1:0]  stride_sh,
  output logic [PAN_W-1:0]           pan_sh
);
  localparam logic [RA_W-1:0] A_PAN    = RA_W'(ofs_pan(ORG_BYTES));
  localparam logic [RA_W-1:0] A_STATUS = RA_W'(ofs_status(ORG_BYTES, STRIDE_BYTES));

  for (genvar i = 0; i < ORG_BYTES; i++) begin : g_org
    localparam logic [RA_W-1:0] A_ME = RA_W'(ofs_org(i));
    always_ff @(posedge clk) begin
      if (!rst_n)                 org_sh[8*i +: 8] <= '0;
      else if (we && ra == A_ME)  org_sh[8*i +: 8] <= wd;
    end
  end

  for (genvar i = 0; i < STRIDE_BYTES; i++) begin : g_stride
    localparam logic [RA_W-1:0] A_ME = RA_W'(ofs_stride(ORG_BYTES, i));
    always_ff @(posedge clk) begin
      if (!rst_n)                 stride_sh[8*i +: 8] <= '0;
      else if (we && ra == A_ME)  stride_sh[8*i +: 8] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pan_sh <= '0;
    else if (we && ra == A_PAN) pan_sh <= wd[PAN_W-1:0];
  end

  always_comb begin
    rd = '0;
    for (int i = 0; i < ORG_BYTES; i++)
      if (ra == RA_W'(ofs_org(i))) rd = org_sh[8*i +: 8];
    for (int i = 0; i < STRIDE_BYTES; i++)
      if (ra == RA_W'(ofs_stride(ORG_BYTES, i))) rd = stride_sh[8*i +: 8];
    if (ra == A_PAN)    rd = {{(HOST_DW-PAN_W){1'b0}}, pan_sh};
    if (ra == A_STATUS) rd = {vnd, {(HOST_DW-1){1'b0}}};
  end

  // R6: a pan write is visible in the shadow one cycle later
  p_pan_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && ra == A_PAN) |=> pan_sh == $past(wd[PAN_W-1:0]));

  // R8: status offset shows only the non-display flag
  p_status_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra == A_STATUS) |-> (rd[HOST_DW-2:0] == '0 && rd[HOST_DW-1] == vnd));
endmodule

// File: rtl/vp_line_gen.sv
module vp_line_gen #(
  parameter int ORG_W    = 24,
  parameter int STRIDE_W = 16,
  parameter int PAN_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start_i,
  input  logic                line_start_i,
  input  logic [ORG_W-1:0]    org_sh_i,
  input  logic [STRIDE_W-1:0] stride_sh_i,
  input  logic [PAN_W-1:0]    pan_sh_i,
  output logic [ORG_W-1:0]    fetch_addr_o,
  output logic [PAN_W-1:0]    pix_shift_o,
  output logic                line_valid_o
);
  logic [ORG_W-1:0]    line_ptr;
  logic [STRIDE_W-1:0] stride_act;
  logic [ORG_W-1:0]    base;
  logic [ORG_W-1:0]    step;

  always_comb begin
    base = frame_start_i ? org_sh_i : line_ptr;
    step = frame_start_i ? ORG_W'(stride_sh_i) : ORG_W'(stride_act);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_ptr     <= '0;
      stride_act   <= '0;
      fetch_addr_o <= '0;
      pix_shift_o  <= '0;
      line_valid_o <= 1'b0;
    end else begin
      line_valid_o <= line_start_i;
      if (frame_start_i) stride_act <= stride_sh_i;
      if (line_start_i) begin
        line_ptr     <= base + step;
        fetch_addr_o <= base;
        pix_shift_o  <= pan_sh_i;
      end else if (frame_start_i) begin
        line_ptr <= base;
      end
    end
  end

  // R4: a lone frame strobe parks the pointer at the shadow offset
  p_frame_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && !line_start_i) |=> line_ptr == $past(org_sh_i));

  // R9: coincident strobes fetch from the offset being captured
  p_frame_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && line_start_i) |=> fetch_addr_o == $past(org_sh_i));

  // R5: mid-frame lines fetch from the running pointer
  p_line_from_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start_i && !frame_start_i) |=> fetch_addr_o == $past(line_ptr));

  // R7: outputs hold when no line strobe occurred
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start_i |=> ($stable(fetch_addr_o) && $stable(pix_shift_o) && !line_valid_o));

  // R6: the shift shown on a line is the shadow at its strobe
  p_pan_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i |=> (line_valid_o && pix_shift_o == $past(pan_sh_i)));
endmodule

// File: rtl/vp_scan_origin.sv
module vp_scan_origin #(
  parameter int ORG_BYTES    = 3,
  parameter int STRIDE_BYTES = 2,
  parameter int PAN_W        = 2,
  parameter int RA_W         = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RA_W-1:0]          host_addr,
  input  logic [7:0]               host_wdata,
  input  logic                     host_we,
  output logic [7:0]               host_rdata,
  input  logic                     vnd_in,
  input  logic                     frame_start,
  input  logic                     line_start,
  output logic [8*ORG_BYTES-1:0]   fetch_addr,
  output logic [PAN_W-1:0]         pix_shift,
  output logic                     line_valid
);
  localparam int ORG_W    = 8 * ORG_BYTES;
  localparam int STRIDE_W = 8 * STRIDE_BYTES;

  logic [ORG_W-1:0]    org_sh;
  logic [STRIDE_W-1:0] stride_sh;
  logic [PAN_W-1:0]    pan_sh;

  vp_host_regs #(
    .ORG_BYTES(ORG_BYTES), .STRIDE_BYTES(STRIDE_BYTES),
    .PAN_W(PAN_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ra(host_addr), .wd(host_wdata),
    .we(host_we), .vnd(vnd_in), .rd(host_rdata),
    .org_sh(org_sh), .stride_sh(stride_sh), .pan_sh(pan_sh)
  );

  vp_line_gen #(
    .ORG_W(ORG_W), .STRIDE_W(STRIDE_W), .PAN_W(PAN_W)
  ) u_lines (
    .clk(clk), .rst_n(rst_n),
    .frame_start_i(frame_start), .line_start_i(line_start),
    .org_sh_i(org_sh), .stride_sh_i(stride_sh), .pan_sh_i(pan_sh),
    .fetch_addr_o(fetch_addr), .pix_shift_o(pix_shift),
    .line_valid_o(line_valid)
  );
endmodule

// File: tb/vp_scan_origin_tb.sv
`timescale 1ns/1ps
module vp_scan_origin_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_addr;
  logic [7:0]  host_wdata;
  logic        host_we;
  logic [7:0]  host_rdata;
  logic        vnd_in;
  logic        frame_start;
  logic        line_start;
  logic [23:0] fetch_addr;
  logic [1:0]  pix_shift;
  logic        line_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  vp_scan_origin dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .vnd_in(vnd_in),
    .frame_start(frame_start), .line_start(line_start),
    .fetch_addr(fetch_addr), .pix_shift(pix_shift), .line_valid(line_valid)
  );

  localparam logic [2:0] K_WR = 3'd0, K_RD = 3'd1, K_FR = 3'd2, K_LN = 3'd3, K_FL = 3'd4;
  localparam int NV = 38;
  // {kind, offset, expected shift, data / expected value}
  localparam logic [31:0] VEC [NV] = '{
    {K_WR,3'd0,2'd0,24'h000034},   // R2 start byte 0
    {K_WR,3'd1,2'd0,24'h000012},   // R2
    {K_WR,3'd2,2'd0,24'h000000},   // R2
    {K_WR,3'd4,2'd0,24'h000040},   // R2 stride lo
    {K_WR,3'd5,2'd0,24'h000001},   // R2 stride hi
    {K_WR,3'd3,2'd0,24'h000002},   // R6 pan
    {K_RD,3'd0,2'd0,24'h000034},   // R2
    {K_RD,3'd1,2'd0,24'h000012},   // R2
    {K_RD,3'd2,2'd0,24'h000000},   // R2
    {K_RD,3'd4,2'd0,24'h000040},   // R2
    {K_RD,3'd5,2'd0,24'h000001},   // R2
    {K_RD,3'd3,2'd0,24'h000002},   // R6
    {K_FR,3'd0,2'd0,24'h000000},
    {K_LN,3'd0,2'd2,24'h001234},   // R4
    {K_LN,3'd0,2'd2,24'h001374},   // R5
    {K_WR,3'd3,2'd0,24'h000001},   // R6 mid-frame pan
    {K_LN,3'd0,2'd1,24'h0014B4},   // R6
    {K_WR,3'd0,2'd0,24'h000000},   // R3 mid-frame start change
    {K_WR,3'd1,2'd0,24'h000000},
    {K_LN,3'd0,2'd1,24'h0015F4},   // R3
    {K_RD,3'd1,2'd0,24'h000000},   // R2
    {K_FR,3'd0,2'd0,24'h000000},
    {K_LN,3'd0,2'd1,24'h000000},   // R4
    {K_LN,3'd0,2'd1,24'h000140},   // R5
    {K_WR,3'd2,2'd0,24'h0000FF},
    {K_WR,3'd1,2'd0,24'h0000FF},
    {K_WR,3'd0,2'd0,24'h0000FF},
    {K_FL,3'd0,2'd1,24'hFFFFFF},   // R9
    {K_LN,3'd0,2'd1,24'h00013F},   // R5 wrap, R9
    {K_WR,3'd3,2'd0,24'h0000FF},
    {K_RD,3'd3,2'd0,24'h000003},   // R10 upper pan bits
    {K_WR,3'd7,2'd0,24'h000055},   // R10 unmapped write
    {K_RD,3'd0,2'd0,24'h0000FF},   // R10
    {K_RD,3'd1,2'd0,24'h0000FF},   // R10
    {K_RD,3'd2,2'd0,24'h0000FF},   // R10
    {K_RD,3'd3,2'd0,24'h000003},   // R10
    {K_RD,3'd4,2'd0,24'h000040},   // R10
    {K_RD,3'd5,2'd0,24'h000001}    // R10
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_we = 0; frame_start = 0; line_start = 0; host_wdata = 0; host_addr = 0;
  endtask

  // entered at a negedge, leaves at the next negedge
  task automatic run_vec(input logic [2:0] k, input logic [2:0] a,
                         input logic [1:0] sh, input logic [23:0] v, input string req);
    host_addr = a;
    case (k)
      K_WR: begin host_we = 1; host_wdata = v[7:0]; end
      K_FR: frame_start = 1;
      K_LN: line_start = 1;
      K_FL: begin frame_start = 1; line_start = 1; end
      default: ;
    endcase
    #1;
    if (k == K_RD) chk(req, {24'h0, host_rdata}, {24'h0, v[7:0]});
    @(negedge clk);
    idle();
    if (k == K_LN || k == K_FL) begin
      chk({req, " addr"}, {8'h0, fetch_addr}, {8'h0, v});
      chk({req, " shift"}, {30'h0, pix_shift}, {30'h0, sh});
      chk({req, " valid"}, {31'h0, line_valid}, 32'h1);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(); vnd_in = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 fetch", {8'h0, fetch_addr}, 0);
    chk("R1 shift", {30'h0, pix_shift}, 0);
    chk("R1 valid", {31'h0, line_valid}, 0);
    for (int a = 0; a < 6; a++) begin
      host_addr = 3'(a); #1;
      chk("R1 shadow", {24'h0, host_rdata}, 0);
    end
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_vec(VEC[i][31:29], VEC[i][28:26], VEC[i][25:24], VEC[i][23:0], $sformatf("vec%0d", i));

    // R7 quiet cycle: pulse drops, values hold at 0x00013F / 1
    @(negedge clk);
    chk("R7 valid low", {31'h0, line_valid}, 0);
    chk("R7 addr hold", {8'h0, fetch_addr}, 32'h00013F);
    chk("R7 shift hold", {30'h0, pix_shift}, 32'h1);

    // R8 status flag
    vnd_in = 1; host_addr = 3'd6; #1;
    chk("R8 vnd high", {24'h0, host_rdata}, 32'h80);
    vnd_in = 0; #1;
    chk("R8 vnd low", {24'h0, host_rdata}, 32'h00);
    @(negedge clk);

    // R3 write in the frame-strobe cycle is missed by that strobe
    host_addr = 3'd0; host_wdata = 8'h11; host_we = 1; frame_start = 1;
    @(negedge clk); idle();
    run_vec(K_LN, 3'd0, 2'd3, 24'hFFFFFF, "R3 same-cycle write");
    run_vec(K_FR, 3'd0, 2'd0, 24'h0, "R3 frame");
    run_vec(K_LN, 3'd0, 2'd3, 24'hFFFF11, "R3 next frame");

    // R1 reset mid-run
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk("R1 re-reset fetch", {8'h0, fetch_addr}, 0);
    host_addr = 3'd0; #1;
    chk("R1 re-reset shadow", {24'h0, host_rdata}, 0);
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule